// File: doc/BRIEF.md
# Transmit Clock Mode Detector

This block watches the transmit clock of each line channel and decides how that channel's transmitter behaves. A clock that keeps toggling means normal operation. A clock stuck high means the line should carry an unbroken run of marks (all ones). A clock stuck low means the channel powers down with its driver in high impedance. Run lengths are measured in cycles of a free-running reference clock. When that reference stops, the transmit clock of one designated fallback channel stands in for it. When both are gone, every channel is forced to high impedance.

All inputs are asynchronous levels. A fast sampling clock brings them in through two-flop synchronizers. "Reference ticks" are the observed rising edges of whichever timing source is active. Each channel emits a bit stream: in normal mode, the channel's data level captured at each observed falling edge of its transmit clock; in all-ones mode, a mark on every reference tick; nothing while in high impedance. The stream has a valid strobe but no ready. A line cannot be stalled, so there is no back-pressure: the consumer must take the bit in every cycle where valid is high.

Top module: `txclk_mode_detect`

## Requirements
- R1: While reset is held, every mode code is 00, and all high-Z enables, all valid strobes and the timing-source flag read 0.
- R2: In normal mode (code 00), each observed falling edge of a channel's transmit clock produces one valid bit equal to that channel's data level at the fall, with bits kept in order.
- R3: A transmit clock that stays high through 16 reference ticks keeps code 00. The 17th tick switches the channel to all-ones mode, code 01, with high-Z 0. Every transition of the clock restarts both the high and the low run counts, and a transition in the same cycle as a tick takes precedence over the tick.
- R4: In all-ones mode a channel gives exactly one valid bit per reference tick, and every such bit is 1.
- R5: A transmit clock that stays low through 63 ticks keeps code 00. The 64th tick selects power-down, code 10, with high-Z 1. From the cycle after high-Z rises, no valid bit leaves that channel.
- R6: A single transition of a stuck transmit clock returns the channel to code 00 at once, with no extra count.
- R7: When no reference rising edge has been seen for REF_TIMEOUT sampling cycles, the timing-source flag goes to 1. Ticks are then the rising edges of channel FB_CH's transmit clock, and the 17-tick and 64-tick rules apply in those ticks.
- R8: If the fallback clock has also shown no rising edge for FB_TIMEOUT cycles while the reference is lost, every channel reports code 11 with high-Z 1 and emits no valid bit.
- R9: The first reference rising edge after an outage clears the timing-source flag. The mode each channel reached by counting is shown again, unchanged by the outage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Active-low reset |
| ref_clk_i | input | 1 | Free-running reference clock, sampled as a level |
| tx_clk_i | input | NCH | Per-channel transmit clocks, sampled as levels |
| tx_data_i | input | NCH | Per-channel transmit data levels |
| mode_o | output | 2*NCH | Per-channel mode code: 00 normal, 01 all ones, 10 power-down, 11 no timing source |
| hiz_o | output | NCH | Per-channel driver high-impedance enable |
| out_valid_o | output | NCH | Per-channel stream strobe, one cycle per bit |
| out_bit_o | output | NCH | Per-channel stream bit, meaningful while valid |
| ref_src_o | output | 1 | 1 while the fallback channel clock is the timing source |

## Verification
The bench builds the block with four channels, channel 1 as the fallback, and both timeouts shortened to 32 sampling cycles. The run thresholds stay at their working values of 16 and 64, so the bench observes the exact boundary ticks on both sides. The short timeouts put reference loss, the switch to fallback timing, the total loss of timing and the recovery within a few dozen cycles each. The bench sets every transmit-clock stop half a reference period away from the nearest tick, and once on the same cycle as a fallback tick, so the tick counts it expects are unambiguous.

// File: rtl/txmd_pkg.sv
package txmd_pkg;
  typedef enum logic [1:0] {
    MD_NORMAL  = 2'b00,
    MD_ALLONES = 2'b01,
    MD_PDOWN   = 2'b10,
    MD_NOREF   = 2'b11
  } txmd_mode_e;
endpackage

// File: rtl/txmd_sync.sv
module txmd_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/txmd_refwatch.sv
module txmd_refwatch #(
  parameter int REF_TIMEOUT = 256,
  parameter int FB_TIMEOUT  = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_lvl_i,
  input  logic fb_lvl_i,
  output logic tick_o,
  output logic ref_src_o,
  output logic noref_o
);
  localparam int RW = $clog2(REF_TIMEOUT + 1);
  localparam int FW = $clog2(FB_TIMEOUT + 1);

  logic          ref_prev_q, fb_prev_q;
  logic [RW-1:0] ref_idle_q;
  logic [FW-1:0] fb_idle_q;
  logic          ref_rise, fb_rise, ref_ok, fb_ok;

  assign ref_rise = ref_lvl_i & ~ref_prev_q;
  assign fb_rise  = fb_lvl_i & ~fb_prev_q;
  assign ref_ok   = ref_idle_q < RW'(REF_TIMEOUT);
  assign fb_ok    = fb_idle_q < FW'(FB_TIMEOUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev_q <= 1'b0;
      fb_prev_q  <= 1'b0;
      ref_idle_q <= '0;
      fb_idle_q  <= '0;
    end else begin
      ref_prev_q <= ref_lvl_i;
      fb_prev_q  <= fb_lvl_i;
      if (ref_rise)     ref_idle_q <= '0;
      else if (ref_ok)  ref_idle_q <= ref_idle_q + 1'b1;
      if (fb_rise)      fb_idle_q  <= '0;
      else if (fb_ok)   fb_idle_q  <= fb_idle_q + 1'b1;
    end
  end

  always_comb begin
    if (ref_ok)     tick_o = ref_rise;
    else if (fb_ok) tick_o = fb_rise;
    else            tick_o = 1'b0;
  end

  assign ref_src_o = ~ref_ok;
  assign noref_o   = ~ref_ok & ~fb_ok;

  // R9: a reference edge always restores primary timing next cycle
  p_ref_edge_restores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> !ref_src_o);
  // R7: once on fallback, stay there until a reference edge arrives
  p_fallback_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ref_src_o) && !$past(ref_rise)) |-> ref_src_o);
  // R8: with no timing source at all, nothing is counted
  p_no_tick_without_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    noref_o |-> !tick_o);
endmodule

// File: rtl/txmd_chan.sv
module txmd_chan
  import txmd_pkg::*;
#(
  parameter int HI_TICKS = 16,
  parameter int LO_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       noref_i,
  input  logic       clk_lvl_i,
  input  logic       data_lvl_i,
  output logic [1:0] mode_o,
  output logic       hiz_o,
  output logic       vld_o,
  output logic       bit_o
);
  localparam int HW = $clog2(HI_TICKS + 1);
  localparam int LW = $clog2(LO_TICKS);

  logic          prev_q;
  logic [HW-1:0] hi_cnt_q;
  logic [LW-1:0] lo_cnt_q;
  txmd_mode_e    mode_q, eff_mode;
  logic          vld_q, bit_q;
  logic          any_edge, fall;

  assign any_edge = clk_lvl_i ^ prev_q;
  assign fall     = prev_q & ~clk_lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      hi_cnt_q <= '0;
      lo_cnt_q <= '0;
      mode_q   <= MD_NORMAL;
    end else begin
      prev_q <= clk_lvl_i;
      if (any_edge) begin
        hi_cnt_q <= '0;
        lo_cnt_q <= '0;
        mode_q   <= MD_NORMAL;
      end else if (tick_i) begin
        if (clk_lvl_i) begin
          lo_cnt_q <= '0;
          if (hi_cnt_q == HW'(HI_TICKS)) mode_q <= MD_ALLONES;
          else                           hi_cnt_q <= hi_cnt_q + 1'b1;
        end else begin
          hi_cnt_q <= '0;
          if (lo_cnt_q == LW'(LO_TICKS - 1)) mode_q <= MD_PDOWN;
          else                               lo_cnt_q <= lo_cnt_q + 1'b1;
        end
      end
    end
  end

  assign eff_mode = noref_i ? MD_NOREF : mode_q;
  assign hiz_o    = (eff_mode == MD_PDOWN) || (eff_mode == MD_NOREF);
  assign mode_o   = eff_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (eff_mode)
        MD_NORMAL: if (fall) begin
          vld_q <= 1'b1;
          bit_q <= data_lvl_i;
        end
        MD_ALLONES: if (tick_i) begin
          vld_q <= 1'b1;
          bit_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign vld_o = vld_q;
  assign bit_o = bit_q;

  // R6: any observed transition brings the channel back to normal
  p_edge_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_edge |=> (mode_q == MD_NORMAL));
  // R4: marks emitted in all-ones mode are ones
  p_allones_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eff_mode == MD_ALLONES) && vld_q) |-> bit_q);
  // R5: a channel that stays in high impedance is silent
  p_quiet_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_o && $past(hiz_o)) |-> !vld_q);
  // R3: a run is either high or low, never both
  p_run_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !((hi_cnt_q != '0) && (lo_cnt_q != '0)));
endmodule

// File: rtl/txclk_mode_detect.sv
module txclk_mode_detect #(
  parameter int NCH         = 8,
  parameter int FB_CH       = 1,
  parameter int HI_TICKS    = 16,
  parameter int LO_TICKS    = 64,
  parameter int REF_TIMEOUT = 256,
  parameter int FB_TIMEOUT  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk_i,
  input  logic [NCH-1:0]   tx_clk_i,
  input  logic [NCH-1:0]   tx_data_i,
  output logic [2*NCH-1:0] mode_o,
  output logic [NCH-1:0]   hiz_o,
  output logic [NCH-1:0]   out_valid_o,
  output logic [NCH-1:0]   out_bit_o,
  output logic             ref_src_o
);
  localparam int SW = 2 * NCH + 1;

  logic [SW-1:0]  sync_in, sync_out;
  logic           ref_lvl;
  logic [NCH-1:0] clk_lvl, data_lvl;
  logic           tick, noref;

  assign sync_in = {ref_clk_i, tx_data_i, tx_clk_i};

  txmd_sync #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sync_in),
    .q_o   (sync_out)
  );

  assign clk_lvl  = sync_out[NCH-1:0];
  assign data_lvl = sync_out[2*NCH-1:NCH];
  assign ref_lvl  = sync_out[SW-1];

  txmd_refwatch #(
    .REF_TIMEOUT (REF_TIMEOUT),
    .FB_TIMEOUT  (FB_TIMEOUT)
  ) u_refwatch (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_lvl_i (ref_lvl),
    .fb_lvl_i  (clk_lvl[FB_CH]),
    .tick_o    (tick),
    .ref_src_o (ref_src_o),
    .noref_o   (noref)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    txmd_chan #(
      .HI_TICKS (HI_TICKS),
      .LO_TICKS (LO_TICKS)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .noref_i    (noref),
      .clk_lvl_i  (clk_lvl[c]),
      .data_lvl_i (data_lvl[c]),
      .mode_o     (mode_o[2*c +: 2]),
      .hiz_o      (hiz_o[c]),
      .vld_o      (out_valid_o[c]),
      .bit_o      (out_bit_o[c])
    );
  end

  // R8: total loss of timing puts every channel in high impedance
  p_all_hiz_noref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    noref |-> (hiz_o == '1));
endmodule

// File: tb/txclk_mode_detect_tb.sv
`timescale 1ns/1ps
module txclk_mode_detect_tb;
  localparam int NCH = 4;
  localparam int FB  = 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic [3:0]       ph = '0;
  logic             ref_run, base, ref_clk;
  logic [NCH-1:0]   run, lvl, tx_clk, tx_data;
  logic [2*NCH-1:0] mode;
  logic [NCH-1:0]   hiz, vld, obit;
  logic             ref_src;

  always @(negedge clk) ph <= ph + 4'd1;
  assign base    = (ph >= 4'd4) && (ph < 4'd12);
  assign ref_clk = ref_run & (ph[2:0] < 3'd4);
  always_comb for (int c = 0; c < NCH; c++) tx_clk[c] = run[c] ? base : lvl[c];

  txclk_mode_detect #(
    .NCH(NCH), .FB_CH(FB), .HI_TICKS(16), .LO_TICKS(64),
    .REF_TIMEOUT(32), .FB_TIMEOUT(32)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .tx_clk_i(tx_clk),
    .tx_data_i(tx_data), .mode_o(mode), .hiz_o(hiz), .out_valid_o(vld),
    .out_bit_o(obit), .ref_src_o(ref_src)
  );

  int n_cmp = 0, n_bad = 0;
  int ones [NCH];
  int zeros[NCH];
  logic q[$];
  logic sb_on = 1'b0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic int mode_of(input int c);
    return int'(mode[2*c +: 2]);
  endfunction

  // monitor: stream counters and scoreboard for channel 0
  initial for (int c = 0; c < NCH; c++) begin ones[c] = 0; zeros[c] = 0; end
  always @(negedge clk) if (rst_n) begin
    for (int c = 0; c < NCH; c++)
      if (vld[c]) begin
        if (obit[c]) ones[c]++; else zeros[c]++;
      end
    if (sb_on && vld[0]) begin
      if (q.size() == 0) check(1'b0, "R2 unexpected bit", int'(obit[0]), -1);
      else begin
        logic e;
        e = q.pop_front();
        check(obit[0] == e, "R2 stream bit", int'(obit[0]), int'(e));
      end
    end
  end

  task automatic wait_ph(input int p);
    do @(posedge clk); while (ph != 4'(p));
    #1;
  endtask

  task automatic wait_ref(input int n);
    repeat (n) do @(posedge clk); while (ph[2:0] != 3'd0);
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic wait_fb(input int n);
    repeat (n) do @(posedge clk); while (ph != 4'd4);
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic stop_clk(input int c, input logic v);
    wait_ph(v ? 5 : 13);
    lvl[c] = v;
    run[c] = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] pat);
    for (int i = 15; i >= 0; i--) begin
      wait_ph(4);
      tx_data[0] = pat[i];
      q.push_back(pat[i]);
      sb_on = 1'b1;
    end
    wait (q.size() == 0);
    @(posedge clk);
    #1;
    sb_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    int o1, z1;
    int t1[NCH];
    rst_n = 1'b0; ref_run = 1'b1; run = '1; lvl = '0; tx_data = '0;
    repeat (5) @(posedge clk);
    #1;
    check(mode == '0, "R1 mode in reset", int'(mode), 0);
    check(hiz == '0 && vld == '0, "R1 hiz/valid in reset", int'({hiz, vld}), 0);
    check(ref_src == 1'b0, "R1 source flag in reset", int'(ref_src), 0);
    rst_n = 1'b1;
    repeat (40) @(posedge clk);
    #1;
    check(mode == '0, "R2 toggling clocks normal", int'(mode), 0);

    // R2: data stream under two patterns
    send_bits(16'hB4D3);
    send_bits(16'h0FF0);
    check(q.size() == 0, "R2 scoreboard drained", q.size(), 0);

    // R3: stuck high on channel 2
    stop_clk(2, 1'b1);
    wait_ref(16);
    check(mode_of(2) == 0, "R3 16 ticks high still normal", mode_of(2), 0);
    wait_ref(1);
    check(mode_of(2) == 1, "R3 17th tick all ones", mode_of(2), 1);
    check(hiz[2] == 1'b0, "R3 all ones keeps driver on", int'(hiz[2]), 0);

    // R4: one mark per tick
    o1 = ones[2]; z1 = zeros[2];
    wait_ref(8);
    check(ones[2] - o1 == 8, "R4 marks per 8 ticks", ones[2] - o1, 8);
    check(zeros[2] == z1, "R4 no zero bits", zeros[2] - z1, 0);

    // R6: one transition restores normal
    wait_ph(6);
    run[2] = 1'b1;
    wait_ph(2);
    check(mode_of(2) == 0, "R6 single fall restores normal", mode_of(2), 0);

    // R5: stuck low on channel 3
    stop_clk(3, 1'b0);
    wait_ref(63);
    check(mode_of(3) == 0, "R5 63 ticks low still normal", mode_of(3), 0);
    wait_ref(1);
    check(mode_of(3) == 2, "R5 64th tick power-down", mode_of(3), 2);
    check(hiz[3] == 1'b1, "R5 power-down high-Z", int'(hiz[3]), 1);
    o1 = ones[3] + zeros[3];
    wait_ref(8);
    check(ones[3] + zeros[3] == o1, "R5 silent while high-Z", ones[3] + zeros[3] - o1, 0);
    wait_ph(14);
    run[3] = 1'b0 | 1'b1;
    wait_ph(10);
    check(mode_of(3) == 0, "R6 single rise restores normal", mode_of(3), 0);

    // R7: reference lost, fallback timing
    wait_ph(5);
    ref_run = 1'b0;
    repeat (48) @(posedge clk);
    #1;
    check(ref_src == 1'b1, "R7 fallback selected", int'(ref_src), 1);
    check(mode == '0, "R7 running clocks stay normal", int'(mode), 0);
    stop_clk(2, 1'b1);
    wait_fb(16);
    check(mode_of(2) == 0, "R7 16 fallback ticks normal", mode_of(2), 0);
    wait_fb(1);
    check(mode_of(2) == 1, "R7 17th fallback tick all ones", mode_of(2), 1);

    // R8: fallback lost too
    stop_clk(FB, 1'b0);
    repeat (48) @(posedge clk);
    #1;
    check(mode == '1, "R8 all channels no-source code", int'(mode), 255);
    check(hiz == '1, "R8 all high-Z", int'(hiz), 15);
    for (int c = 0; c < NCH; c++) t1[c] = ones[c] + zeros[c];
    repeat (32) @(posedge clk);
    #1;
    for (int c = 0; c < NCH; c++)
      check(ones[c] + zeros[c] == t1[c], "R8 no valid bits", ones[c] + zeros[c] - t1[c], 0);

    // R9: reference back
    wait_ph(5);
    ref_run = 1'b1;
    repeat (16) @(posedge clk);
    #1;
    check(ref_src == 1'b0, "R9 primary timing restored", int'(ref_src), 0);
    check(mode_of(0) == 0, "R9 channel 0 normal again", mode_of(0), 0);
    check(mode_of(2) == 1, "R9 all-ones state kept", mode_of(2), 1);
    check(hiz[2] == 1'b0, "R9 driver re-enabled", int'(hiz[2]), 0);

    summary();
  end
endmodule